// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter that feeds a three-digit readout. It closes the input integration switch for a fixed number of timebase ticks, then closes the opposite-polarity reference switch and counts ticks until an external comparator reports that the integrator charge is back at its starting level. That count, together with a sign bit sampled when integration starts, becomes the reading. The reading is formatted as three BCD digits and scanned out one digit at a time, with a one-hot digit select. The analog parts, the comparator and the oscillator sit outside the block. All timing is taken from a one-cycle `tick` enable.

The sequencer has three states. IDLE waits out the gap between conversions. The transition IDLE→INTEG fires on the tick that completes the gap, and it samples the sign. INTEG holds the input switch closed. The transition INTEG→DEINT fires on the tick that completes the integration interval and clears the counter. DEINT holds the reference switch closed and counts ticks. The transition DEINT→IDLE fires on a comparator trip, which gives a normal result, or on the tick after the counter has reached its ceiling, which gives a timeout result. The DEINT→IDLE cycle is the completion cycle, and in it the formatted result is written to the display register unless hold is selected. The mode input selects slow rate (00 or 11), fast rate (01) or hold (10). Once hold has been seen, a sticky flag that only reset clears keeps the gap at the slow length.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and directly after it, both switch outputs are low, `dig_sel` is 100 (most significant digit) and `bcd` is 0000. The display register holds 0,0,0.
- R2: `sw_int` stays high for exactly INT_TICKS ticks, and then `sw_ref` goes high in the cycle that `sw_int` goes low. The two switch outputs are never high together.
- R3: The reading is the number of ticks that occur in DEINT before `cmp_trip` is seen high. A trip ends DEINT in the same cycle, with priority over a tick.
- R4: A positive reading from 0 to 999 is shown as hundreds, tens and units in the MSD, NSD and LSD positions.
- R5: A negative reading from 0 to 99 is shown as the minus code 1010 in the MSD, followed by tens and units.
- R6: A positive reading above 999 shows 1011 in all three digits. A negative reading above 99 shows 1010 in all three digits.
- R7: If DEINT receives a tick while the count equals MAX_CNT and no trip is present, the conversion ends and the display shows 1011 in all three digits, whatever the sign.
- R8: After a conversion, IDLE lasts FAST_GAP ticks when mode is 01 and hold has never been selected. Otherwise it lasts SLOW_GAP ticks, which covers modes 00 and 11.
- R9: In a cycle where mode is 10 (hold), the display register does not change. Conversions continue with the SLOW_GAP idle length.
- R10: After hold is released, completed conversions update the display again, but the idle length stays SLOW_GAP, even in mode 01, until reset.
- R11: `dig_sel` is always one-hot and steps on each tick in the order 100 (MSD), 010 (NSD), 001 (LSD) and back to 100. `bcd` always carries the digit that is selected.
- R12: `sign_neg` is sampled only on the IDLE→INTEG transition. A change during INTEG or DEINT has no effect on that reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per count |
| mode | input | 2 | 00 slow, 01 fast, 10 hold, 11 slow |
| cmp_trip | input | 1 | Comparator: integrator charge restored |
| sign_neg | input | 1 | Input polarity, 1 = negative |
| sw_int | output | 1 | Close input integration switch |
| sw_ref | output | 1 | Close reference de-integration switch |
| dig_sel | output | 3 | One-hot digit select: bit 2 MSD, bit 1 NSD, bit 0 LSD |
| bcd | output | 4 | BCD value of the selected digit |

## Verification
Conversions use de-integration counts drawn at random from four bands: under 100, under 1000, close to the 999/1000 boundary, and the full counter range. Each count is paired with a random sign and a random non-hold mode, so the same count is seen both as a positive reading and as a negative one. This separates the ordinary digit split from the minus-sign layout and from both overrange codes. Directed cases add exact boundaries (0, 99, 100, 999, 1000, negative zero) and a comparator that never trips, which separates overrange from timeout. The idle length is measured after every conversion, and the sign input is flipped during each conversion. A hold-then-release sequence shows that the display freezes and that the slow rate stays in force, which a bench that watched only the display would miss.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_SLOW = 2'b00;
    localparam logic [1:0] MODE_FAST = 2'b01;
    localparam logic [1:0] MODE_HOLD = 2'b10;

    localparam logic [3:0] BCD_MINUS = 4'b1010;
    localparam logic [3:0] BCD_OVER  = 4'b1011;
endpackage

// File: rtl/dsc_seq.sv
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int INT_TICKS = 1000,
    parameter int MAX_CNT   = 1999,
    parameter int FAST_GAP  = 100,
    parameter int SLOW_GAP  = 4000,
    localparam int CNT_W    = $clog2(MAX_CNT + 1),
    localparam int INT_W    = $clog2(INT_TICKS + 1),
    localparam int GAP_MAX  = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP,
    localparam int GAP_W    = $clog2(GAP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic             cmp_trip,
    input  logic             sign_neg,
    output logic             sw_int,
    output logic             sw_ref,
    output logic             done,
    output logic             res_tmo,
    output logic             res_neg,
    output logic [CNT_W-1:0] res_cnt
);
    seq_state_t       state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_lim;
    logic [INT_W-1:0] int_q;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_q, lock_q, fast;

    assign fast    = (mode == MODE_FAST) && !lock_q;
    assign gap_lim = fast ? GAP_W'(FAST_GAP - 1) : GAP_W'(SLOW_GAP - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick && gap_q >= gap_lim) state_d = ST_INTEG;
            ST_INTEG: if (tick && int_q == INT_W'(INT_TICKS - 1)) state_d = ST_DEINT;
            ST_DEINT: if (cmp_trip || (tick && cnt_q == CNT_W'(MAX_CNT))) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            int_q   <= '0;
            cnt_q   <= '0;
            neg_q   <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_q | (mode == MODE_HOLD);
            unique case (state_q)
                ST_IDLE: if (tick) begin
                    if (state_d == ST_INTEG) begin
                        gap_q <= '0;
                        int_q <= '0;
                        neg_q <= sign_neg;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_INTEG: if (tick) begin
                    if (state_d == ST_DEINT) begin
                        int_q <= '0;
                        cnt_q <= '0;
                    end else begin
                        int_q <= int_q + 1'b1;
                    end
                end
                ST_DEINT: begin
                    if (state_d == ST_IDLE) gap_q <= '0;
                    else if (tick)          cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sw_int  = (state_q == ST_INTEG);
        sw_ref  = (state_q == ST_DEINT);
        done    = (state_q == ST_DEINT) && (state_d == ST_IDLE);
        res_tmo = !cmp_trip;
        res_neg = neg_q;
        res_cnt = cnt_q;
    end

    AST_SW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_int && sw_ref)); // R2
    AST_DEINT_AFTER_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref) |-> $past(sw_int)); // R2
    AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R10
    AST_SIGN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT) |=> $stable(neg_q)); // R12
endmodule

// File: rtl/dsc_fmt.sv
module dsc_fmt
    import dsc_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             neg,
    input  logic             tmo,
    output logic [11:0]      digits
);
    int unsigned cv;

    always_comb begin
        cv = 32'(cnt);
        if (tmo || (!neg && cv > 999))
            digits = {BCD_OVER, BCD_OVER, BCD_OVER};
        else if (neg && cv > 99)
            digits = {BCD_MINUS, BCD_MINUS, BCD_MINUS};
        else if (neg)
            digits = {BCD_MINUS, 4'((cv / 10) % 10), 4'(cv % 10)};
        else
            digits = {4'((cv / 100) % 10), 4'((cv / 10) % 10), 4'(cv % 10)};
    end
endmodule

// File: rtl/dsc_scan.sv
module dsc_scan (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [11:0] disp,
    output logic [2:0]  dig_sel,
    output logic [3:0]  bcd
);
    logic [2:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sel_q <= 3'b100;
        else if (tick) sel_q <= {sel_q[0], sel_q[2:1]};
    end

    always_comb begin
        dig_sel = sel_q;
        if (sel_q[2])      bcd = disp[11:8];
        else if (sel_q[1]) bcd = disp[7:4];
        else               bcd = disp[3:0];
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_sel) == 1); // R11
    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dig_sel)); // R11
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsc_pkg::*;
#(
    parameter int INT_TICKS = 1000,
    parameter int MAX_CNT   = 1999,
    parameter int FAST_GAP  = 100,
    parameter int SLOW_GAP  = 4000,
    localparam int CNT_W    = $clog2(MAX_CNT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       cmp_trip,
    input  logic       sign_neg,
    output logic       sw_int,
    output logic       sw_ref,
    output logic [2:0] dig_sel,
    output logic [3:0] bcd
);
    logic             done, res_tmo, res_neg;
    logic [CNT_W-1:0] res_cnt;
    logic [11:0]      fmt_digits, disp_q;

    dsc_seq #(
        .INT_TICKS(INT_TICKS), .MAX_CNT(MAX_CNT),
        .FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .cmp_trip(cmp_trip), .sign_neg(sign_neg),
        .sw_int(sw_int), .sw_ref(sw_ref), .done(done),
        .res_tmo(res_tmo), .res_neg(res_neg), .res_cnt(res_cnt)
    );

    dsc_fmt #(.CNT_W(CNT_W)) u_fmt (
        .cnt(res_cnt), .neg(res_neg), .tmo(res_tmo), .digits(fmt_digits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          disp_q <= '0;
        else if (done && mode != MODE_HOLD)  disp_q <= fmt_digits;
    end

    dsc_scan u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .disp(disp_q),
        .dig_sel(dig_sel), .bcd(bcd)
    );

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(disp_q)); // R9
    AST_DISP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(disp_q)); // R3
endmodule

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;
    localparam int INT_T = 16;
    localparam int MAXC  = 1023;
    localparam int FGAP  = 10;
    localparam int SGAP  = 30;
    localparam int LIM   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cmp_trip = 1'b0;
    logic       sign_neg = 1'b0;
    logic       sw_int, sw_ref;
    logic [2:0] dig_sel;
    logic [3:0] bcd;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  first = 1'b1;
    bit  lock_m = 1'b0;
    logic [11:0] disp_m = 12'h000;
    bit  reported = 1'b0;

    always #10 clk = ~clk;

    dual_slope_seq #(
        .INT_TICKS(INT_T), .MAX_CNT(MAXC), .FAST_GAP(FGAP), .SLOW_GAP(SGAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .cmp_trip(cmp_trip), .sign_neg(sign_neg),
        .sw_int(sw_int), .sw_ref(sw_ref), .dig_sel(dig_sel), .bcd(bcd)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_disp(bit neg, int k, bit tmo);
        if (tmo || (!neg && k > 999)) return 12'hBBB;
        if (neg && k > 99)            return 12'hAAA;
        if (neg) return {4'hA, 4'(k / 10), 4'(k % 10)};
        return {4'(k / 100), 4'((k / 10) % 10), 4'(k % 10)};
    endfunction

    function automatic string disp_tag(bit neg, int k, bit tmo);
        if (tmo) return "R7 timeout";
        if ((!neg && k > 999) || (neg && k > 99)) return "R6 overrange";
        if (neg) return "R5 negative";
        return "R4 positive";
    endfunction

    task automatic read_display(input string tag);
        logic [11:0] got = '0;
        logic [2:0]  prev = '0;
        for (int i = 0; i < 3; i++) begin
            check("R11 one-hot select", $countones(dig_sel), 1);
            if (i > 0) check("R11 scan order", dig_sel, {prev[0], prev[2:1]});
            prev = dig_sel;
            if (dig_sel[2]) got[11:8] = bcd;
            if (dig_sel[1]) got[7:4]  = bcd;
            if (dig_sel[0]) got[3:0]  = bcd;
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
        check(tag, got, disp_m);
    endtask

    task automatic run_conv(input bit neg, input int k, input logic [1:0] md, input string gap_tag);
        int  n = 0;
        int  m = 0;
        int  gap;
        bit  tmo = (k > MAXC);
        mode = md;
        sign_neg = neg;
        if (md == 2'b10) lock_m = 1'b1;
        gap = ((md == 2'b01) && !lock_m) ? FGAP : SGAP;
        while (!sw_int && n < LIM) begin
            tick = 1'b1; n++; @(negedge clk);
        end
        check(gap_tag, n, first ? gap : gap - 3);
        first = 1'b0;
        sign_neg = !neg;                       // R12: late change must be ignored
        while (!sw_ref && m < LIM) begin
            tick = 1'b1; m++; @(negedge clk);
        end
        check("R2 integrate length", m, INT_T);
        check("R2 input switch open", sw_int, 0);
        for (int i = 0; i < k; i++) begin
            tick = 1'b1; @(negedge clk);
        end
        tick = 1'b0;
        if (!tmo) begin
            cmp_trip = 1'b1; @(negedge clk); cmp_trip = 1'b0;
        end
        check(tmo ? "R7 back to idle" : "R3 trip ends de-integration", sw_ref, 0);
        if (md != 2'b10) disp_m = exp_disp(neg, k, tmo);
        read_display(md == 2'b10 ? "R9 hold freezes display" :
                     (lock_m ? "R10 display after hold" : disp_tag(neg, k, tmo)));
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] mds [3] = '{2'b00, 2'b01, 2'b11};
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset sw_int", sw_int, 0);
        check("R1 reset sw_ref", sw_ref, 0);
        check("R1 reset select", dig_sel, 3'b100);
        check("R1 reset bcd", bcd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset select", dig_sel, 3'b100);

        // directed corners
        run_conv(1'b0, 0,    2'b01, "R8 fast gap");
        run_conv(1'b0, 999,  2'b01, "R8 fast gap");
        run_conv(1'b0, 1000, 2'b00, "R8 slow gap");
        run_conv(1'b1, 99,   2'b11, "R8 slow gap");
        run_conv(1'b1, 100,  2'b01, "R8 fast gap");
        run_conv(1'b1, 0,    2'b01, "R8 fast gap");
        run_conv(1'b1, 7,    2'b00, "R8 slow gap");
        run_conv(1'b1, MAXC + 1, 2'b01, "R8 fast gap");
        run_conv(1'b0, MAXC, 2'b01, "R8 fast gap");

        // constrained random
        for (int t = 0; t < 24; t++) begin
            int band = $urandom % 4;
            int k;
            bit ng = 1'($urandom % 2);
            logic [1:0] md = mds[$urandom % 3];
            case (band)
                0: k = $urandom % 100;
                1: k = $urandom % 1000;
                2: k = 995 + ($urandom % 16);
                default: k = $urandom % (MAXC + 1);
            endcase
            run_conv(ng, k, md, md == 2'b01 ? "R8 fast gap" : "R8 slow gap");
        end

        // hold, then release
        run_conv(1'b0, 321, 2'b10, "R9 hold slow gap");
        run_conv(1'b1, 42,  2'b10, "R9 hold slow gap");
        run_conv(1'b0, 456, 2'b01, "R10 slow after hold");
        run_conv(1'b1, 5,   2'b01, "R10 slow after hold");
        finish_run();
    end
endmodule